// File: doc/BRIEF.md
# Serial Port Interrupt Register Set

This block gathers the event sources of a serial peripheral into one interrupt line. Seven source bits share a single layout across four registers: a status register whose latched bits are cleared by writing ones, an enable register that only sets mask bits, a disable register that only clears them, and a read-only view of the current mask. The request line is high whenever any status bit is both latched and unmasked.

Sources are a mix of single-cycle pulses (receive overrun, mode fault, transmit underflow) and live levels (transmit FIFO full, receive FIFO not empty, receive FIFO full). A seventh source is derived here: the transmit FIFO occupancy is compared against a programmable watermark, and the source is active while occupancy is strictly below it. A level source holds its status bit set for as long as its condition lasts, so clearing it has no effect until the condition goes away.

Software uses a flat register bus: the address selects a register, a write strobe with data performs a write, and read data follows the address in the same cycle. Reads have no side effects.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset the status register reads 0, the mask reads 0, the watermark reads 1 and `irq_o` is low.
- R2: A pulse on a source latches its status bit one clock later, and the bit stays set until cleared; bit positions are 0 receive overrun, 1 mode fault, 5 receive full, 6 transmit underflow.
- R3: A write to offset 0x04 clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R4: When a source event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: A write to offset 0x08 sets every mask bit written as 1 and leaves the others; the mask reads back at offset 0x10.
- R6: A write to offset 0x0C clears every mask bit written as 1 and leaves the others.
- R7: Reads of offsets 0x08, 0x0C and any unmapped offset return 0.
- R8: `irq_o` is high exactly when some status bit and its mask bit are both 1.
- R9: The watermark register at offset 0x28 is read/write; status bit 2 is raised while `tx_level_i` is strictly below it and not when equal.
- R10: Status bit 3 (transmit full) and bit 4 (receive not empty) stay set through a clearing write while their input is high, and clear on a write once it is low.
- R11: A write to the mask view at offset 0x10 changes neither the mask nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address |
| mode_fault_i | input | 1 | Mode fault pulse |
| rx_overrun_i | input | 1 | Receive overrun pulse |
| tx_underflow_i | input | 1 | Transmit underflow pulse |
| tx_full_i | input | 1 | Transmit FIFO full level |
| rx_not_empty_i | input | 1 | Receive FIFO not empty level |
| rx_full_i | input | 1 | Receive FIFO full level |
| tx_level_i | input | LVL_W | Transmit FIFO occupancy |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check, bit by bit, that a source event latches, that a latched bit holds until it is written with a one, that a clearing write removes a bit only when no event hits it, and that mask bits move only on the set and clear strobes while the watermark changes only on its own write. The bench's scenarios show what those local checks cannot: the address decode that routes each offset to the right strobe, zero reads of write-only and unmapped offsets, the strict-below comparison at the watermark boundary, and the level sources re-latching through a clear while the request line tracks the mask.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
    // number of interrupt sources, shared by all four registers
    localparam int NSRC = 7;

    // source bit positions (software decodes these)
    localparam int B_RXOVR  = 0;
    localparam int B_MODEF  = 1;
    localparam int B_TXLOW  = 2;
    localparam int B_TXFULL = 3;
    localparam int B_RXNE   = 4;
    localparam int B_RXFULL = 5;
    localparam int B_TXUND  = 6;

    // register byte offsets
    localparam int OFS_STAT  = 'h04;
    localparam int OFS_SET   = 'h08;
    localparam int OFS_CLR   = 'h0C;
    localparam int OFS_MASK  = 'h10;
    localparam int OFS_WMARK = 'h28;

    localparam int WMARK_RST = 1;
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond
    import irq_regs_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             mode_fault_i,
    input  logic             rx_overrun_i,
    input  logic             tx_underflow_i,
    input  logic             tx_full_i,
    input  logic             rx_not_empty_i,
    input  logic             rx_full_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [LVL_W-1:0] wmark_i,
    output logic [NSRC-1:0]  raw_o
);
    always_comb begin
        raw_o           = '0;
        raw_o[B_RXOVR]  = rx_overrun_i;
        raw_o[B_MODEF]  = mode_fault_i;
        raw_o[B_TXLOW]  = (tx_level_i < wmark_i);
        raw_o[B_TXFULL] = tx_full_i;
        raw_o[B_RXNE]   = rx_not_empty_i;
        raw_o[B_RXFULL] = rx_full_i;
        raw_o[B_TXUND]  = tx_underflow_i;
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int N = 7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] raw_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_bits_i,
    output logic [N-1:0] stat_o
);
    logic [N-1:0] stat_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stat_q[g] <= 1'b0;
            end else if (raw_i[g]) begin
                stat_q[g] <= 1'b1;          // event has priority over clear
            end else if (clr_we_i && clr_bits_i[g]) begin
                stat_q[g] <= 1'b0;
            end
        end

        AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            raw_i[g] |=> stat_q[g]);                                       // R4
        AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_we_i && clr_bits_i[g] && !raw_i[g]) |=> !stat_q[g]);     // R3
        AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_q[g] && !(clr_we_i && clr_bits_i[g])) |=> stat_q[g]);    // R2
        AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!stat_q[g] && !raw_i[g]) |=> !stat_q[g]);                     // R2
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int N = 7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         set_we_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] bits_i,
    output logic [N-1:0] mask_o
);
    logic [N-1:0] mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else if (clr_we_i) begin
            mask_q <= mask_q & ~bits_i;
        end else if (set_we_i) begin
            mask_q <= mask_q | bits_i;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (set_we_i && !clr_we_i && bits_i[g]) |=> mask_q[g]);           // R5
        AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_we_i && bits_i[g]) |=> !mask_q[g]);                       // R6
        AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((set_we_i || clr_we_i) && !bits_i[g]) |=> $stable(mask_q[g])); // R5
    end

    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_we_i && !clr_we_i) |=> $stable(mask_q));                     // R11

    assign mask_o = mask_q;
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import irq_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              mode_fault_i,
    input  logic              rx_overrun_i,
    input  logic              tx_underflow_i,
    input  logic              tx_full_i,
    input  logic              rx_not_empty_i,
    input  logic              rx_full_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_WMARK = ADDR_W'(OFS_WMARK);

    logic             we_stat, we_set, we_clr, we_wmark;
    logic [NSRC-1:0]  wbits, raw, stat, mask;
    logic [LVL_W-1:0] wmark_q;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata_i;

    // write decode
    assign we_stat  = bus_wr_i && (bus_addr_i == A_STAT);
    assign we_set   = bus_wr_i && (bus_addr_i == A_SET);
    assign we_clr   = bus_wr_i && (bus_addr_i == A_CLR);
    assign we_wmark = bus_wr_i && (bus_addr_i == A_WMARK);
    assign wbits    = bus_wdata_i[NSRC-1:0];

    // transmit watermark
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wmark_q <= LVL_W'(WMARK_RST);
        end else if (we_wmark) begin
            wmark_q <= bus_wdata_i[LVL_W-1:0];
        end
    end

    AST_WM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_wmark |=> $stable(wmark_q));                                   // R9

    irq_src_cond #(.LVL_W(LVL_W)) u_cond (
        .mode_fault_i   (mode_fault_i),
        .rx_overrun_i   (rx_overrun_i),
        .tx_underflow_i (tx_underflow_i),
        .tx_full_i      (tx_full_i),
        .rx_not_empty_i (rx_not_empty_i),
        .rx_full_i      (rx_full_i),
        .tx_level_i     (tx_level_i),
        .wmark_i        (wmark_q),
        .raw_o          (raw)
    );

    irq_status_reg #(.N(NSRC)) u_stat (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .raw_i      (raw),
        .clr_we_i   (we_stat),
        .clr_bits_i (wbits),
        .stat_o     (stat)
    );

    irq_mask_reg #(.N(NSRC)) u_mask (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_we_i (we_set),
        .clr_we_i (we_clr),
        .bits_i   (wbits),
        .mask_o   (mask)
    );

    // read mux: write-only and unmapped offsets return zero
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == A_STAT) begin
            bus_rdata_o = DATA_W'(stat);
        end else if (bus_addr_i == A_MASK) begin
            bus_rdata_o = DATA_W'(mask);
        end else if (bus_addr_i == A_WMARK) begin
            bus_rdata_o = DATA_W'(wmark_q);
        end
    end

    assign irq_o = |(stat & mask);

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask == '0) |-> !irq_o);                                          // R8
endmodule

// File: tb/sim_spi_irq_regs.sv
module sim_spi_irq_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mode_fault = 1'b0, rx_ovr = 1'b0, tx_und = 1'b0;
    logic        tx_full = 1'b0, rx_ne = 1'b0, rx_full = 1'b0;
    logic [7:0]  tx_level = 8'd5;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    spi_irq_regs u0 (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .mode_fault_i(mode_fault), .rx_overrun_i(rx_ovr), .tx_underflow_i(tx_und),
        .tx_full_i(tx_full), .rx_not_empty_i(rx_ne), .rx_full_i(rx_full),
        .tx_level_i(tx_level), .irq_o(irq)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic       wr;
        logic [7:0] addr;
        logic [6:0] wd;
        logic       mf;
        logic       ovr;
        logic [6:0] est;
        logic [6:0] emk;
        logic       eirq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  1'b0, 8'h00, 7'h00, 1'b1, 1'b0, 7'h02, 7'h00, 1'b0},
        '{4'd5,  1'b1, 8'h08, 7'h02, 1'b0, 1'b0, 7'h02, 7'h02, 1'b1},
        '{4'd2,  1'b0, 8'h00, 7'h00, 1'b0, 1'b1, 7'h03, 7'h02, 1'b1},
        '{4'd3,  1'b1, 8'h04, 7'h02, 1'b0, 1'b0, 7'h01, 7'h02, 1'b0},
        '{4'd5,  1'b1, 8'h08, 7'h41, 1'b0, 1'b0, 7'h01, 7'h43, 1'b1},
        '{4'd6,  1'b1, 8'h0C, 7'h01, 1'b0, 1'b0, 7'h01, 7'h42, 1'b0},
        '{4'd4,  1'b1, 8'h04, 7'h01, 1'b0, 1'b1, 7'h01, 7'h42, 1'b0},
        '{4'd11, 1'b1, 8'h10, 7'h7F, 1'b0, 1'b0, 7'h01, 7'h42, 1'b0},
        '{4'd3,  1'b1, 8'h04, 7'h7F, 1'b0, 1'b0, 7'h00, 7'h42, 1'b0},
        '{4'd8,  1'b0, 8'h00, 7'h00, 1'b1, 1'b0, 7'h02, 7'h42, 1'b1},
        '{4'd6,  1'b1, 8'h0C, 7'h7F, 1'b0, 1'b0, 7'h02, 7'h00, 1'b0},
        '{4'd5,  1'b1, 8'h08, 7'h00, 1'b0, 1'b0, 7'h02, 7'h00, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [7:0] a, input logic [31:0] d,
                         input logic mf, input logic ovr);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; mode_fault = mf; rx_ovr = ovr;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; mode_fault = 1'b0; rx_ovr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(8'h04, v); check("R1 status", v, 0);
        rd(8'h10, v); check("R1 mask", v, 0);
        rd(8'h28, v); check("R1 watermark", v, 1);
        check("R1 irq", {31'b0, irq}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].wr, TBL[i].addr, {25'b0, TBL[i].wd}, TBL[i].mf, TBL[i].ovr);
            rd(8'h04, v);
            check($sformatf("R%0d vec%0d status", TBL[i].rq, i), v, {25'b0, TBL[i].est});
            rd(8'h10, v);
            check($sformatf("R%0d vec%0d mask", TBL[i].rq, i), v, {25'b0, TBL[i].emk});
            check($sformatf("R8 vec%0d irq", i), {31'b0, irq}, {31'b0, TBL[i].eirq});
        end

        // R7 write-only and unmapped offsets read zero
        drive(1'b1, 8'h08, 32'h15, 1'b0, 1'b0);
        rd(8'h08, v); check("R7 enable read", v, 0);
        rd(8'h0C, v); check("R7 disable read", v, 0);
        rd(8'h3C, v); check("R7 unmapped read", v, 0);
        rd(8'h10, v); check("R5 mask after set", v, 32'h15);
        drive(1'b1, 8'h0C, 32'h7F, 1'b0, 1'b0);
        drive(1'b1, 8'h04, 32'h7F, 1'b0, 1'b0);
        rd(8'h04, v); check("R3 clear all", v, 0);

        // R9 watermark compare, strict below
        drive(1'b1, 8'h28, 32'd8, 1'b0, 1'b0);
        rd(8'h28, v); check("R9 watermark readback", v, 8);
        drive(1'b0, 8'h00, 0, 1'b0, 1'b0);
        rd(8'h04, v); check("R9 level 5 below 8", v, 32'h04);
        drive(1'b1, 8'h04, 32'h04, 1'b0, 1'b0);
        rd(8'h04, v); check("R9 persists through clear", v, 32'h04);
        tx_level = 8'd8;
        drive(1'b1, 8'h04, 32'h04, 1'b0, 1'b0);
        rd(8'h04, v); check("R9 equal is not below", v, 0);
        tx_level = 8'd7;
        drive(1'b0, 8'h00, 0, 1'b0, 1'b0);
        rd(8'h04, v); check("R9 one below", v, 32'h04);
        tx_level = 8'd9;
        drive(1'b1, 8'h04, 32'h04, 1'b0, 1'b0);
        rd(8'h04, v); check("R9 above clears", v, 0);

        // R10 level sources re-latch through a clear
        tx_full = 1'b1;
        drive(1'b0, 8'h00, 0, 1'b0, 1'b0);
        rd(8'h04, v); check("R10 tx full set", v, 32'h08);
        drive(1'b1, 8'h04, 32'h08, 1'b0, 1'b0);
        rd(8'h04, v); check("R10 tx full persists", v, 32'h08);
        tx_full = 1'b0;
        drive(1'b1, 8'h04, 32'h08, 1'b0, 1'b0);
        rd(8'h04, v); check("R10 tx full cleared", v, 0);
        rx_ne = 1'b1;
        drive(1'b1, 8'h08, 32'h10, 1'b0, 1'b0);
        rd(8'h04, v); check("R10 rx not empty set", v, 32'h10);
        check("R8 irq from rx not empty", {31'b0, irq}, 1);
        drive(1'b1, 8'h04, 32'h10, 1'b0, 1'b0);
        rd(8'h04, v); check("R10 rx not empty persists", v, 32'h10);
        check("R8 irq held", {31'b0, irq}, 1);
        rx_ne = 1'b0;
        drive(1'b1, 8'h04, 32'h10, 1'b0, 1'b0);
        rd(8'h04, v); check("R10 rx not empty cleared", v, 0);
        check("R8 irq dropped", {31'b0, irq}, 0);

        // R2 remaining pulse sources at bits 5 and 6
        rx_full = 1'b1;
        drive(1'b0, 8'h00, 0, 1'b0, 1'b0);
        rx_full = 1'b0;
        @(negedge clk); tx_und = 1'b1;
        @(posedge clk); #1; tx_und = 1'b0;
        rd(8'h04, v); check("R2 bits 5 and 6", v, 32'h60);

        finish_run();
    end
endmodule